// File: doc/BRIEF.md
# Double-Buffered PWM Pair with Dead-Time Insertion

This block turns one timer into a pair of pulse-width outputs. A clock prescaler and a power-of-two divider produce a counter tick. A 16-bit counter counts down from a period value and sets the first output high when it matches a compare value. It drives that output low again when it reloads at the period end. The second output is the complement of the first while the timer runs. With dead-time insertion enabled, each rising edge on either output is held back by a programmed number of prescaler ticks, so the pair never conducts together.

The period and compare inputs act as holding registers. The counter takes them only when it starts and each time it reaches zero, so the host may change them at any point without tearing the waveform that is running. In auto-reload mode the waveform repeats. In one-shot mode the timer produces one period and then parks. Each arrival at zero sets a sticky interrupt flag, which a one-cycle clear pulse removes.

A three-state controller sequences the counter. IDLE holds everything low until `run` is raised, and the start transition (IDLE to COUNT) loads the counter. COUNT steps the counter on every tick. At zero, the reload transition (COUNT to COUNT) fetches the period again in auto-reload mode, and the stop transition (COUNT to HALT) ends the waveform in one-shot mode. Dropping `run` takes COUNT or HALT back to IDLE (the abort and release transitions).

Top module: `pwm_dz_pair`

## Requirements
- R1: After reset, `pwm_a`, `pwm_b` and `irq_flag` are 0. One cycle after `run` is seen low, both outputs are 0.
- R2: The counter tick period is T = (`prescale`+1) * 2^k clocks. Here k is `div_sel` for codes 0 to 4 (divide by 1, 2, 4, 8, 16), and codes 5 to 7 divide by 16. The counter changes only on a tick.
- R3: In auto-reload mode with period value N, the rising edges of `pwm_a` repeat every (N+1)*T clocks.
- R4: With compare value C < N, `pwm_a` is high for (C+1)*T clocks of each period. With C = N it stays high. With C > N it never goes high.
- R5: New `period_buf` and `cmp_buf` values do not change the period that is running. They take effect from the next reload at zero.
- R6: `irq_flag` is set each time the counter reaches zero and stays set until `irq_clr` is high at a clock edge. A clear in the same cycle as a zero arrival leaves the flag set.
- R7: In one-shot mode the counter reaches zero once and raises the flag once. Both outputs then stay low until `run` is dropped.
- R8: With `dz_en` = 0, `pwm_b` is the exact complement of `pwm_a` while the timer runs.
- R9: With `dz_en` = 1, every rising edge of each output is delayed by `dead_time`*(`prescale`+1) clocks, falling edges are not delayed, and the two outputs are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Timer enable; low returns the controller to IDLE |
| one_shot | input | 1 | 1: stop after one period, 0: auto-reload |
| prescale | input | 8 | Prescaler value; the prescaler divides the clock by prescale+1 |
| div_sel | input | 3 | Divider select, 0..4 = /1,/2,/4,/8,/16, 5..7 = /16 |
| period_buf | input | 16 | Period holding value N |
| cmp_buf | input | 16 | Compare holding value C |
| dz_en | input | 1 | Dead-time insertion enable |
| dead_time | input | 8 | Rising-edge delay in prescaler ticks |
| irq_clr | input | 1 | Clears the interrupt flag |
| pwm_a | output | 1 | First PWM output |
| pwm_b | output | 1 | Second, complementary PWM output |
| irq_flag | output | 1 | Sticky period-end flag |

## Verification
The hardest situations to reach from the ports depend on exact timing. One is a holding-register change that lands after a reload but before the compare match. The other is a flag clear in the very cycle the counter arrives at zero. The bench first synchronises to a falling edge of `pwm_a`, which marks a reload. It then changes both holding values and measures the next two pulses and periods, expecting the old values first and the new values after. For the collision, it times a clear pulse from the known period so that the clear reaches the clock edge of the next zero arrival. Random prescaler, divider, period and compare settings then cover the tick arithmetic.

// File: rtl/pwm_dz_pkg.sv
package pwm_dz_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_HALT  = 2'd2
    } pwm_state_e;

endpackage

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen #(
    parameter int PRE_W      = 8,
    parameter int DIV_STAGES = 4,
    parameter int SEL_W      = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PRE_W-1:0] prescale,
    input  logic [SEL_W-1:0] div_sel,
    output logic             pre_tick,
    output logic             tick
);

    logic [PRE_W-1:0]      pre_cnt;
    logic [DIV_STAGES-1:0] div_cnt;
    logic [DIV_STAGES-1:0] div_mask;

    // one mask bit per divider stage; codes past the last stage saturate
    always_comb begin
        div_mask = '0;
        for (int i = 0; i < DIV_STAGES; i++) begin
            if (int'(div_sel) > i) div_mask[i] = 1'b1;
        end
    end

    assign pre_tick = run && (pre_cnt >= prescale);
    assign tick     = pre_tick && ((div_cnt & div_mask) == div_mask);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_cnt <= '0;
            div_cnt <= '0;
        end else if (!run) begin
            pre_cnt <= '0;
            div_cnt <= '0;
        end else if (pre_tick) begin
            pre_cnt <= '0;
            div_cnt <= div_cnt + 1'b1;
        end else begin
            pre_cnt <= pre_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/pwm_period_fsm.sv
module pwm_period_fsm
    import pwm_dz_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             one_shot,
    input  logic             tick,
    input  logic [CNT_W-1:0] period_buf,
    input  logic [CNT_W-1:0] cmp_buf,
    output pwm_state_e       state_q,
    output logic [CNT_W-1:0] cnt_q,
    output logic             raw_q,
    output logic             active,
    output logic             zero_evt
);

    pwm_state_e       state_nx;
    logic [CNT_W-1:0] cmp_q;
    logic [CNT_W-1:0] cnt_nx;
    logic             at_zero;
    logic             load;
    logic             dec;

    assign at_zero = (cnt_q == '0);
    assign load    = ((state_q == ST_IDLE) && run) ||
                     ((state_q == ST_COUNT) && run && tick && at_zero && !one_shot);
    assign dec     = (state_q == ST_COUNT) && run && tick && !at_zero;
    assign cnt_nx  = load ? period_buf : (dec ? cnt_q - 1'b1 : cnt_q);
    assign zero_evt = (load || dec) && (cnt_nx == '0);
    assign active  = (state_q == ST_COUNT);

    // next-state logic
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE:  if (run) state_nx = ST_COUNT;
            ST_COUNT: begin
                if (!run)                              state_nx = ST_IDLE;
                else if (tick && at_zero && one_shot)  state_nx = ST_HALT;
            end
            ST_HALT:  if (!run) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    // counter, active compare and raw output
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            cmp_q <= '0;
            raw_q <= 1'b0;
        end else begin
            cnt_q <= (state_nx == ST_COUNT) ? cnt_nx : '0;
            if (load) cmp_q <= cmp_buf;
            if (state_nx != ST_COUNT)  raw_q <= 1'b0;
            else if (load)             raw_q <= (period_buf == cmp_buf);
            else if (dec && (cnt_nx == cmp_q)) raw_q <= 1'b1;
        end
    end

endmodule

// File: rtl/pwm_dead_delay.sv
module pwm_dead_delay #(
    parameter int DT_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            pre_tick,
    input  logic [DT_W-1:0] dead_time,
    input  logic            din,
    output logic            dout
);

    logic [DT_W-1:0] hold_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                hold_cnt <= '0;
        else if (!din)                             hold_cnt <= '0;
        else if (pre_tick && (hold_cnt < dead_time)) hold_cnt <= hold_cnt + 1'b1;
    end

    assign dout = en ? (din && (hold_cnt >= dead_time)) : din;

endmodule

// File: rtl/pwm_dz_pair.sv
module pwm_dz_pair
    import pwm_dz_pkg::*;
#(
    parameter  int CNT_W      = 16,
    parameter  int PRE_W      = 8,
    parameter  int DT_W       = 8,
    parameter  int DIV_STAGES = 4,
    localparam int SEL_W      = $clog2(DIV_STAGES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             one_shot,
    input  logic [PRE_W-1:0] prescale,
    input  logic [SEL_W-1:0] div_sel,
    input  logic [CNT_W-1:0] period_buf,
    input  logic [CNT_W-1:0] cmp_buf,
    input  logic             dz_en,
    input  logic [DT_W-1:0]  dead_time,
    input  logic             irq_clr,
    output logic             pwm_a,
    output logic             pwm_b,
    output logic             irq_flag
);

    localparam int N_OUT = 2;

    logic             pre_tick;
    logic             tick;
    pwm_state_e       state_w;
    logic [CNT_W-1:0] cnt_w;
    logic             raw_w;
    logic             active_w;
    logic             zero_evt;
    logic [N_OUT-1:0] pre_out;
    logic [N_OUT-1:0] fin_out;

    pwm_tick_gen #(
        .PRE_W(PRE_W), .DIV_STAGES(DIV_STAGES), .SEL_W(SEL_W)
    ) u_tick (
        .clk(clk), .rst_n(rst_n), .run(run),
        .prescale(prescale), .div_sel(div_sel),
        .pre_tick(pre_tick), .tick(tick)
    );

    pwm_period_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .run(run), .one_shot(one_shot),
        .tick(tick), .period_buf(period_buf), .cmp_buf(cmp_buf),
        .state_q(state_w), .cnt_q(cnt_w), .raw_q(raw_w),
        .active(active_w), .zero_evt(zero_evt)
    );

    assign pre_out = {active_w & ~raw_w, raw_w};

    for (genvar g = 0; g < N_OUT; g++) begin : g_dz
        pwm_dead_delay #(.DT_W(DT_W)) u_dly (
            .clk(clk), .rst_n(rst_n), .en(dz_en), .pre_tick(pre_tick),
            .dead_time(dead_time), .din(pre_out[g]), .dout(fin_out[g])
        );
    end

    assign pwm_a = fin_out[0];
    assign pwm_b = fin_out[1];

    // sticky flag, a zero arrival wins over a clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        irq_flag <= 1'b0;
        else if (zero_evt) irq_flag <= 1'b1;
        else if (irq_clr)  irq_flag <= 1'b0;
    end

endmodule

// File: rtl/pwm_dz_pair_chk.sv
module pwm_dz_pair_chk
    import pwm_dz_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run,
    input logic             dz_en,
    input logic             irq_clr,
    input logic             pwm_a,
    input logic             pwm_b,
    input logic             irq_flag,
    input pwm_state_e       state,
    input logic             tick,
    input logic [CNT_W-1:0] cnt,
    input logic             zero_evt
);

    AST_IDLE_OUTS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (!pwm_a && !pwm_b)); // R1

    AST_CNT_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COUNT && run && !tick) |=> $stable(cnt)); // R2

    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag && !irq_clr) |=> irq_flag); // R6

    AST_FLAG_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        zero_evt |=> irq_flag); // R6

    AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clr && !zero_evt) |=> !irq_flag); // R6

    AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALT) |-> (!pwm_a && !pwm_b)); // R7

    AST_COMPLEMENT: assert property (@(posedge clk) disable iff (!rst_n)
        (!dz_en && state == ST_COUNT) |-> (pwm_a ^ pwm_b)); // R8

    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(pwm_a && pwm_b)); // R9

endmodule

bind pwm_dz_pair pwm_dz_pair_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .run(run), .dz_en(dz_en), .irq_clr(irq_clr),
    .pwm_a(pwm_a), .pwm_b(pwm_b), .irq_flag(irq_flag),
    .state(state_w), .tick(tick), .cnt(cnt_w), .zero_evt(zero_evt)
);

// File: tb/tb_pwm_dz_pair.sv
`timescale 1ns/1ps
module tb_pwm_dz_pair;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic        one_shot = 1'b0;
    logic [7:0]  prescale = '0;
    logic [2:0]  div_sel = '0;
    logic [15:0] period_buf = '0;
    logic [15:0] cmp_buf = '0;
    logic        dz_en = 1'b0;
    logic [7:0]  dead_time = '0;
    logic        irq_clr = 1'b0;
    logic        pwm_a, pwm_b, irq_flag;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    int overlap = 0;

    pwm_dz_pair dut (
        .clk(clk), .rst_n(rst_n), .run(run), .one_shot(one_shot),
        .prescale(prescale), .div_sel(div_sel), .period_buf(period_buf),
        .cmp_buf(cmp_buf), .dz_en(dz_en), .dead_time(dead_time),
        .irq_clr(irq_clr), .pwm_a(pwm_a), .pwm_b(pwm_b), .irq_flag(irq_flag)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual %0d cycles expected under 150000", cyc);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    always @(negedge clk) if (rst_n && pwm_a && pwm_b) overlap++;

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int tick_len(input int p, input int d);
        return (p + 1) * (1 << ((d > 4) ? 4 : d));
    endfunction

    function automatic logic sig(input int w);
        case (w)
            0: return pwm_a;
            1: return pwm_b;
            default: return irq_flag;
        endcase
    endfunction

    task automatic wait_level(input int w, input logic lvl, output int t);
        int n = 0;
        @(negedge clk);
        while (sig(w) !== lvl && n < 5000) begin
            @(negedge clk);
            n++;
        end
        t = cyc;
    endtask

    task automatic wait_rise(input int w, output int t);
        int d;
        wait_level(w, 1'b0, d);
        wait_level(w, 1'b1, t);
    endtask

    task automatic wait_fall(input int w, output int t);
        int d;
        wait_level(w, 1'b1, d);
        wait_level(w, 1'b0, t);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic start(input int p, input int d, input int n, input int c,
                         input logic os, input logic dz, input int dt);
        @(negedge clk);
        run = 1'b0;
        idle(2);
        prescale = p[7:0]; div_sel = d[2:0];
        period_buf = n[15:0]; cmp_buf = c[15:0];
        one_shot = os; dz_en = dz; dead_time = dt[7:0];
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
        run = 1'b1;
    endtask

    initial begin
        int t1, t2, t3, t4, tt, cnt;
        int p, d, n, c;
        void'($urandom(32'd4242));
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset pwm_a", int'(pwm_a), 0);
        check("R1 reset pwm_b", int'(pwm_b), 0);
        check("R1 reset irq_flag", int'(irq_flag), 0);

        // random auto-reload configurations, dead time off
        for (int it = 0; it < 6; it++) begin
            p = $urandom % 3;
            d = $urandom % 5;
            n = 2 + $urandom % 8;
            c = $urandom % n;
            tt = tick_len(p, d);
            start(p, d, n, c, 1'b0, 1'b0, 0);
            wait_rise(0, t1);
            wait_fall(0, t2);
            check("R8 pwm_b complements pwm_a", int'(pwm_b), 1);
            wait_rise(0, t3);
            check("R4 high time", t2 - t1, (c + 1) * tt);
            check("R3 R2 period", t3 - t1, (n + 1) * tt);
        end
        @(negedge clk);
        run = 1'b0;
        idle(1);
        check("R1 pwm_a low after run drop", int'(pwm_a), 0);
        check("R1 pwm_b low after run drop", int'(pwm_b), 0);

        // divider code above the last stage divides by 16
        start(0, 6, 3, 1, 1'b0, 1'b0, 0);
        wait_rise(0, t1); wait_fall(0, t2); wait_rise(0, t3);
        check("R2 sel 6 high time", t2 - t1, 32);
        check("R2 sel 6 period", t3 - t1, 64);

        // compare above period: pwm_a never high
        start(0, 1, 3, 5, 1'b0, 1'b0, 0);
        cnt = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (pwm_a) cnt++;
        end
        check("R4 cmp above period stays low", cnt, 0);

        // compare equal to period: pwm_a always high
        start(0, 1, 4, 4, 1'b0, 1'b0, 0);
        idle(3);
        cnt = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (!pwm_a) cnt++;
        end
        check("R4 cmp equal period stays high", cnt, 0);

        // holding registers change after a reload, before the match
        start(1, 0, 9, 2, 1'b0, 1'b0, 0);
        wait_fall(0, t1);
        cmp_buf = 16'd4;
        period_buf = 16'd5;
        wait_rise(0, t2); wait_fall(0, t3);
        check("R5 old compare kept", t3 - t2, 6);
        check("R5 old period kept", t3 - t1, 20);
        wait_rise(0, t2); wait_fall(0, t4);
        check("R5 new compare used", t4 - t2, 10);
        check("R5 new period used", t4 - t3, 12);

        // flag hold, clear and set-over-clear collision
        start(0, 1, 5, 2, 1'b0, 1'b0, 0);
        wait_fall(0, t1);
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
        wait_level(2, 1'b1, t1);
        idle(3);
        check("R6 flag held", int'(irq_flag), 1);
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
        check("R6 flag cleared", int'(irq_flag), 0);
        idle(7);
        check("R6 flag still clear", int'(irq_flag), 0);
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
        check("R6 set wins over clear", int'(irq_flag), 1);

        // one-shot
        start(0, 0, 4, 1, 1'b1, 1'b0, 0);
        cnt = 0; t1 = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            irq_clr = 1'b0;
            if (irq_flag) begin
                cnt++;
                irq_clr = 1'b1;
            end
            if (pwm_a && t2 == 0) t1++;
            t2 = int'(pwm_a);
        end
        irq_clr = 1'b0;
        check("R7 single zero event", cnt, 1);
        check("R7 single pulse", t1, 1);
        check("R7 pwm_a parked low", int'(pwm_a), 0);
        check("R7 pwm_b parked low", int'(pwm_b), 0);

        // dead-time insertion
        overlap = 0;
        start(1, 1, 7, 3, 1'b0, 1'b1, 3);
        wait_rise(0, t1);
        wait_fall(0, t2);
        wait_rise(1, t3);
        wait_fall(1, t4);
        check("R9 pwm_a shortened high", t2 - t1, 10);
        check("R9 rising edge delay", t3 - t2, 6);
        check("R9 pwm_b shortened high", t4 - t3, 10);
        idle(40);
        check("R9 outputs never both high", overlap, 0);

        @(negedge clk);
        run = 1'b0;
        idle(2);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule